// File: doc/BRIEF.md
# Power Domain Sequencer

This block drives the control bits for a set of switchable power domains on a chip. Each domain has three masks, fixed at build time: the power switch bits it owns, its isolation bits and its unit reset bits. When software or a controller asks for a domain to go up or down, the block walks through the three control registers in a fixed order. It changes one register per step and holds each step for a programmable number of cycles, so that rails can settle and resets can propagate before the next change.

Three 32-bit control registers can also be read and written directly through a simple register port while no sequence is running. This direct path lets software pulse one reset line, or set up state by hand. The block drives only the control bits. The analog switches and the isolation cells sit outside it.

Polarities differ by register. A power bit at 1 means the domain is off. An isolation bit at 0 means the domain is isolated. A reset bit at 0 holds the unit in reset.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset, `pwrCtl` is all zeros (every domain on), while `isoCtl` and `rstCtl` are all ones (isolation off, resets released). `busy` and `done` are both 0 after reset.
- R2: The register port decodes three addresses: power at 0x10, software reset at 0x30 and isolation at 0x58. A read of any other address returns 0, and a write to any other address has no effect. `regRdData` follows `regAddr` combinationally.
- R3: A write while idle replaces the whole addressed register, and the new value is visible after that clock edge. Writing a reset bit to 0 and then back to 1, with all other bits unchanged, gives a reset pulse on that one line.
- R4: A power-off request runs three steps in this order. First it clears the domain's isolation bits (isolation on). Then it clears the domain's reset bits (reset held). Last it sets the domain's power bits (power off). Only the masked bits change.
- R5: A power-on request runs three steps in this order. First it clears the domain's power bits (power on). Then it sets the domain's reset bits (reset released). Last it sets the domain's isolation bits (isolation off). Only the masked bits change.
- R6: If a domain's isolation mask is zero, its isolation step is skipped. If its reset mask is zero, its reset step is skipped. The skipped step takes no cycles. The power step always runs.
- R7: The request is accepted at a clock edge. `busy` is 1 from that edge on. Step i becomes visible at edge 1 + i*(1+H) after the accept edge, where H is the value of `stepHold` when the request was accepted.
- R8: With n steps in the sequence, `done` is 1 for exactly one cycle, beginning at edge n*(1+H) after the accept edge. `busy` drops at that same edge.
- R9: While `busy` is 1, new requests and register writes have no effect. A request whose domain index is not below the number of domains is also ignored.
- R10: During a sequence, at most one of the three control registers changes on any clock edge. While idle with no write, none of them changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 8 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| reqValid | input | 1 | Sequence request strobe |
| reqDomain | input | 2 | Domain index of the request |
| reqPowerOn | input | 1 | 1 = power the domain up, 0 = power it down |
| stepHold | input | 8 | Extra cycles to hold after each step |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence ends |
| pwrCtl | output | 32 | Power control bits (1 = off) |
| isoCtl | output | 32 | Isolation control bits (0 = isolated) |
| rstCtl | output | 32 | Software reset bits (0 = in reset) |

## Verification
Sequences are run in both directions, on domains with all three masks and on a domain with power only. This tells the full three-step order apart from the skipped-step order, and from a design that spends cycles on empty steps. Hold values of 0 up to 3 separate a step that is applied once and held from one that repeats or lands late. All three registers are sampled after every step, so a wrong order or a touched unmasked bit shows up.

Other runs fire a second request and a write in the middle of a sequence, and make requests with an invalid domain index. Random direct writes, including to unmapped addresses, mixed with random requests, check that the sequencer's read-modify-write keeps the bits that software set by hand.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned OFS_PWR  = 'h10;
  localparam int unsigned OFS_RST  = 'h30;
  localparam int unsigned OFS_ISO  = 'h58;

  typedef enum logic [1:0] {
    STEP_PWR = 2'd0,
    STEP_RST = 2'd1,
    STEP_ISO = 2'd2
  } stepKind_e;

  // Strobe bundle from the sequencer to the register datapath
  typedef struct packed {
    logic      apply;
    stepKind_e kind;
    logic      powerOn;
    logic [7:0] dom;
  } seqStrobe_t;
endpackage

// File: rtl/pds_ctrl.sv
module pds_ctrl
  import pds_pkg::*;
#(
  parameter int NUM_DOMAINS = 3,
  parameter int HOLD_W      = 8,
  parameter int IDX_W       = 2,
  parameter logic [NUM_DOMAINS-1:0][REG_W-1:0] RST_MASKS = '0,
  parameter logic [NUM_DOMAINS-1:0][REG_W-1:0] ISO_MASKS = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [IDX_W-1:0]  reqDomain,
  input  logic              reqPowerOn,
  input  logic [HOLD_W-1:0] stepHold,
  output seqStrobe_t        strobe,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {S_IDLE, S_APPLY, S_HOLD} state_e;

  localparam logic [1:0] POS_NONE = 2'd3;

  state_e            state;
  logic [1:0]        pos;
  logic [HOLD_W-1:0] cnt;
  logic [HOLD_W-1:0] holdLen;
  logic [IDX_W-1:0]  dom;
  logic              powerOn;
  logic [1:0]        nextPos;
  logic              reqOk;

  // Step order per direction: up = power, reset, isolation; down = reverse
  function automatic stepKind_e kindAt(input logic [1:0] p, input logic up);
    stepKind_e k;
    if (up) begin
      case (p)
        2'd0:    k = STEP_PWR;
        2'd1:    k = STEP_RST;
        default: k = STEP_ISO;
      endcase
    end else begin
      case (p)
        2'd0:    k = STEP_ISO;
        2'd1:    k = STEP_RST;
        default: k = STEP_PWR;
      endcase
    end
    return k;
  endfunction

  function automatic logic stepLive(input stepKind_e k, input logic [IDX_W-1:0] d);
    logic live;
    case (k)
      STEP_RST: live = (RST_MASKS[d] != '0);
      STEP_ISO: live = (ISO_MASKS[d] != '0);
      default:  live = 1'b1;
    endcase
    return live;
  endfunction

  // First live step at or after position start, POS_NONE if none remains
  function automatic logic [1:0] findFrom(input logic [2:0] start, input logic up,
                                          input logic [IDX_W-1:0] d);
    logic [1:0] r;
    r = POS_NONE;
    for (int p = 2; p >= 0; p--) begin
      if (p >= int'(start) && stepLive(kindAt(2'(p), up), d)) r = 2'(p);
    end
    return r;
  endfunction

  assign reqOk   = (32'(reqDomain) < NUM_DOMAINS);
  assign nextPos = findFrom({1'b0, pos} + 3'd1, powerOn, dom);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pos     <= '0;
      cnt     <= '0;
      holdLen <= '0;
      dom     <= '0;
      powerOn <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (reqValid && reqOk) begin
            dom     <= reqDomain;
            powerOn <= reqPowerOn;
            holdLen <= stepHold;
            pos     <= findFrom(3'd0, reqPowerOn, reqDomain);
            state   <= S_APPLY;
          end
        end
        S_APPLY: begin
          if (holdLen != '0) begin
            cnt   <= holdLen;
            state <= S_HOLD;
          end else if (nextPos == POS_NONE) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            pos <= nextPos;
          end
        end
        S_HOLD: begin
          if (cnt == HOLD_W'(1)) begin
            if (nextPos == POS_NONE) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              pos   <= nextPos;
              state <= S_APPLY;
            end
          end else begin
            cnt <= cnt - HOLD_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy           = (state != S_IDLE);
  assign strobe.apply   = (state == S_APPLY);
  assign strobe.kind    = kindAt(pos, powerOn);
  assign strobe.powerOn = powerOn;
  assign strobe.dom     = 8'(dom);
endmodule

// File: rtl/pds_datapath.sv
module pds_datapath
  import pds_pkg::*;
#(
  parameter int NUM_DOMAINS = 3,
  parameter int ADDR_W      = 8,
  parameter int IDX_W       = 2,
  parameter logic [NUM_DOMAINS-1:0][REG_W-1:0] PWR_MASKS = '0,
  parameter logic [NUM_DOMAINS-1:0][REG_W-1:0] RST_MASKS = '0,
  parameter logic [NUM_DOMAINS-1:0][REG_W-1:0] ISO_MASKS = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              busy,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic [REG_W-1:0]  pwrCtl,
  output logic [REG_W-1:0]  isoCtl,
  output logic [REG_W-1:0]  rstCtl
);
  localparam logic [ADDR_W-1:0] A_PWR = ADDR_W'(OFS_PWR);
  localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(OFS_RST);
  localparam logic [ADDR_W-1:0] A_ISO = ADDR_W'(OFS_ISO);

  logic [IDX_W-1:0] selDom;
  logic [REG_W-1:0] pMask, rMask, iMask;
  logic             wrOk;

  assign selDom = strobe.dom[IDX_W-1:0];
  assign pMask  = PWR_MASKS[selDom];
  assign rMask  = RST_MASKS[selDom];
  assign iMask  = ISO_MASKS[selDom];
  assign wrOk   = regWrEn && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrCtl <= '0;
      isoCtl <= '1;
      rstCtl <= '1;
    end else if (strobe.apply) begin
      case (strobe.kind)
        STEP_PWR: pwrCtl <= strobe.powerOn ? (pwrCtl & ~pMask) : (pwrCtl | pMask);
        STEP_RST: rstCtl <= strobe.powerOn ? (rstCtl | rMask)  : (rstCtl & ~rMask);
        STEP_ISO: isoCtl <= strobe.powerOn ? (isoCtl | iMask)  : (isoCtl & ~iMask);
        default: ;
      endcase
    end else if (wrOk) begin
      if (regAddr == A_PWR) pwrCtl <= regWrData;
      if (regAddr == A_RST) rstCtl <= regWrData;
      if (regAddr == A_ISO) isoCtl <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == A_PWR) regRdData = pwrCtl;
    if (regAddr == A_RST) regRdData = rstCtl;
    if (regAddr == A_ISO) regRdData = isoCtl;
  end
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
  import pds_pkg::*;
#(
  parameter int NUM_DOMAINS = 3,
  parameter int ADDR_W      = 8,
  parameter int HOLD_W      = 8,
  parameter int IDX_W       = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS + 1) : 1,
  parameter logic [NUM_DOMAINS-1:0][REG_W-1:0] PWR_MASKS =
    {32'h0000_0010, 32'h0000_0004, 32'h0000_0008},
  parameter logic [NUM_DOMAINS-1:0][REG_W-1:0] RST_MASKS =
    {32'h0000_0000, 32'h0004_0000, 32'h0001_0000},
  parameter logic [NUM_DOMAINS-1:0][REG_W-1:0] ISO_MASKS =
    {32'h0000_0000, 32'h0000_0002, 32'h0000_0001}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              reqValid,
  input  logic [IDX_W-1:0]  reqDomain,
  input  logic              reqPowerOn,
  input  logic [HOLD_W-1:0] stepHold,
  output logic              busy,
  output logic              done,
  output logic [REG_W-1:0]  pwrCtl,
  output logic [REG_W-1:0]  isoCtl,
  output logic [REG_W-1:0]  rstCtl
);
  seqStrobe_t seqStb;

  pds_ctrl #(
    .NUM_DOMAINS(NUM_DOMAINS), .HOLD_W(HOLD_W), .IDX_W(IDX_W),
    .RST_MASKS(RST_MASKS), .ISO_MASKS(ISO_MASKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDomain(reqDomain),
    .reqPowerOn(reqPowerOn), .stepHold(stepHold), .strobe(seqStb),
    .busy(busy), .done(done)
  );

  pds_datapath #(
    .NUM_DOMAINS(NUM_DOMAINS), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .PWR_MASKS(PWR_MASKS), .RST_MASKS(RST_MASKS), .ISO_MASKS(ISO_MASKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(seqStb), .busy(busy),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .pwrCtl(pwrCtl), .isoCtl(isoCtl), .rstCtl(rstCtl)
  );
endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
  parameter int NUM_DOMAINS = 3,
  parameter int ADDR_W      = 8,
  parameter int HOLD_W      = 8,
  parameter int IDX_W       = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [31:0]       regWrData,
  input logic [31:0]       regRdData,
  input logic              reqValid,
  input logic [IDX_W-1:0]  reqDomain,
  input logic              reqPowerOn,
  input logic [HOLD_W-1:0] stepHold,
  input logic              busy,
  input logic              done,
  input logic [31:0]       pwrCtl,
  input logic [31:0]       isoCtl,
  input logic [31:0]       rstCtl
);
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_accept_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && (32'(reqDomain) < NUM_DOMAINS)) |=> busy);

  a_r9_bad_domain_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && (32'(reqDomain) >= NUM_DOMAINS)) |=> !busy);

  a_r10_one_reg_per_edge: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($countones({pwrCtl != $past(pwrCtl), isoCtl != $past(isoCtl),
                          rstCtl != $past(rstCtl)}) <= 1));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !regWrEn) |=> ($stable(pwrCtl) && $stable(isoCtl) && $stable(rstCtl)));
endmodule

bind pwr_domain_seq pds_checker #(
  .NUM_DOMAINS(NUM_DOMAINS), .ADDR_W(ADDR_W), .HOLD_W(HOLD_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/test_pwr_domain_seq.sv
module test_pwr_domain_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqValid = 1'b0;
  logic [1:0]  reqDomain = '0;
  logic        reqPowerOn = 1'b0;
  logic [7:0]  stepHold = '0;
  logic        busy, done;
  logic [31:0] pwrCtl, isoCtl, rstCtl;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] mPwr, mIso, mRst;

  always #5 clk = ~clk;

  pwr_domain_seq i_pwr_domain_seq (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqDomain(reqDomain), .reqPowerOn(reqPowerOn), .stepHold(stepHold),
    .busy(busy), .done(done), .pwrCtl(pwrCtl), .isoCtl(isoCtl), .rstCtl(rstCtl)
  );

  // Domain masks as given by the requirements (build defaults)
  function automatic logic [31:0] pm(input int d);
    case (d) 0: return 32'h8; 1: return 32'h4; default: return 32'h10; endcase
  endfunction
  function automatic logic [31:0] im(input int d);
    case (d) 0: return 32'h1; 1: return 32'h2; default: return 32'h0; endcase
  endfunction
  function automatic logic [31:0] rm(input int d);
    case (d) 0: return 32'h0001_0000; 1: return 32'h0004_0000; default: return 32'h0; endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic checkRegs(input string tag);
    check(pwrCtl == mPwr, {tag, " pwrCtl"}, pwrCtl, mPwr);
    check(isoCtl == mIso, {tag, " isoCtl"}, isoCtl, mIso);
    check(rstCtl == mRst, {tag, " rstCtl"}, rstCtl, mRst);
  endtask

  // Apply step kind (0 pwr, 1 rst, 2 iso) to the bench model
  task automatic modelStep(input int kind, input int d, input bit up);
    case (kind)
      0: mPwr = up ? (mPwr & ~pm(d)) : (mPwr | pm(d));
      1: mRst = up ? (mRst | rm(d))  : (mRst & ~rm(d));
      default: mIso = up ? (mIso | im(d)) : (mIso & ~im(d));
    endcase
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    regAddr = a; regWrData = v; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
    if (a == 8'h10) mPwr = v;
    if (a == 8'h30) mRst = v;
    if (a == 8'h58) mIso = v;
  endtask

  task automatic readCheck(input logic [7:0] a, input string tag);
    logic [31:0] e;
    e = (a == 8'h10) ? mPwr : (a == 8'h30) ? mRst : (a == 8'h58) ? mIso : 32'h0;
    regAddr = a;
    #2;
    check(regRdData == e, {tag, " readback"}, regRdData, e);
  endtask

  task automatic runSeq(input int d, input bit up, input int h, input bit intrude);
    int kinds[3];
    int n = 0;
    int total;
    string tag;
    tag = up ? "R5" : "R4";
    for (int p = 0; p < 3; p++) begin
      int k;
      k = up ? p : 2 - p;  // up: pwr,rst,iso; down: iso,rst,pwr
      if (k == 0 || (k == 1 && rm(d) != 0) || (k == 2 && im(d) != 0)) begin
        kinds[n] = k;
        n++;
      end
    end
    total = n * (1 + h);
    @(negedge clk);
    reqValid = 1'b1; reqDomain = 2'(d); reqPowerOn = up; stepHold = 8'(h);
    @(posedge clk); #1;
    reqValid = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", 32'(busy), 32'd1);
    for (int c = 1; c <= total; c++) begin
      if (intrude && c == 1) begin
        reqValid = 1'b1; reqDomain = 2'((d + 1) % 3); reqPowerOn = !up;
        regAddr = 8'h10; regWrData = 32'hFFFF_FFFF; regWrEn = 1'b1;
      end
      @(posedge clk); #1;
      if (intrude && c == 1) begin
        reqValid = 1'b0; regWrEn = 1'b0;
      end
      if ((c - 1) % (1 + h) == 0) begin
        modelStep(kinds[(c - 1) / (1 + h)], d, up);
        checkRegs(intrude ? {tag, " R9 step"} : {tag, " R7 step"});
      end
      if (c < total)
        check(busy && !done, "R7 busy held mid-sequence", {30'd0, busy, done}, 32'd2);
      else
        check(!busy && done, (n < 3) ? "R6 R8 done at end" : "R8 done at end",
              {30'd0, busy, done}, 32'd1);
    end
    @(posedge clk); #1;
    check(!done && !busy, "R8 R9 done single and idle after", {30'd0, busy, done}, 32'd0);
    checkRegs({tag, " R9 final"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    mPwr = '0; mIso = '1; mRst = '1;
    repeat (3) @(posedge clk);
    #1;
    checkRegs("R1 reset");
    check(!busy && !done, "R1 busy/done in reset", {30'd0, busy, done}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    checkRegs("R1 after release");

    readCheck(8'h10, "R2 pwr");
    readCheck(8'h58, "R2 iso");
    readCheck(8'h30, "R2 rst");
    writeReg(8'h44, 32'h1234_5678);
    checkRegs("R2 unmapped write");
    readCheck(8'h44, "R2 unmapped read");

    // reset pulse on one line by clear then set
    writeReg(8'h30, mRst & ~32'h20);
    readCheck(8'h30, "R3 pulse low");
    check(rstCtl[5] == 1'b0, "R3 line held", 32'(rstCtl[5]), 32'd0);
    writeReg(8'h30, mRst | 32'h20);
    readCheck(8'h30, "R3 pulse high");

    runSeq(0, 1'b0, 0, 1'b0);
    runSeq(0, 1'b1, 2, 1'b0);
    runSeq(2, 1'b0, 1, 1'b0);
    runSeq(2, 1'b1, 0, 1'b0);
    runSeq(1, 1'b0, 3, 1'b1);
    runSeq(1, 1'b1, 1, 1'b1);

    // out-of-range domain is ignored
    @(negedge clk);
    reqValid = 1'b1; reqDomain = 2'd3; reqPowerOn = 1'b0;
    @(posedge clk); #1;
    reqValid = 1'b0;
    check(!busy, "R9 bad domain ignored", 32'(busy), 32'd0);
    checkRegs("R9 bad domain regs");

    for (int i = 0; i < 40; i++) begin
      int sel;
      sel = int'($urandom % 4);
      if ($urandom % 3 == 0) begin
        logic [7:0] a;
        a = (sel == 0) ? 8'h10 : (sel == 1) ? 8'h30 : (sel == 2) ? 8'h58 : 8'h20;
        writeReg(a, $urandom);
        readCheck(a, "R3 random write");
      end else if (sel == 3) begin
        @(negedge clk);
        reqValid = 1'b1; reqDomain = 2'd3; reqPowerOn = 1'($urandom);
        @(posedge clk); #1;
        reqValid = 1'b0;
        check(!busy, "R9 random bad domain", 32'(busy), 32'd0);
      end else begin
        runSeq(sel, 1'($urandom), int'($urandom % 4), 1'($urandom));
      end
    end
    summary();
  end
endmodule